// File: doc/BRIEF.md
# Gated Counter Snapshot Register with Access Resolver

This block keeps a 64-bit snapshot of a free-running instruction counter. On any clock edge where a capture strobe arrives together with a capture-success indication, the counter value presented at the input is copied into the snapshot. A strobe without the success indication leaves the stored value alone.

Software reads the snapshot through a system-register access port. Each request carries a five-field register encoding, the current exception level, and a set of feature-present flags and control bits. The block checks that the encoding names this register. It then runs an ordered permission check and reports one of four outcomes: read data, undefined instruction, trap to EL2 or trap to EL3. Both trap outcomes carry the class code 0x18. The outcome is registered and appears one cycle after the request.

A two-state response machine sequences the port. In state `S_IDLE` no outcome is presented. A request in any state moves the machine to `S_RESP` for the next cycle (transition *accept*). A cycle without a request returns it to `S_IDLE` (transition *retire*).

Top module: `snap_access_unit`

## Requirements
- R1: On a rising clock edge where `cap_strobe` and `cap_ok` are both high, the snapshot takes the value of `cnt_value`. A later permitted read returns that value on `rsp_data`.
- R2: A rising edge with `cap_strobe` high and `cap_ok` low leaves the snapshot unchanged.
- R3: A read requested in the same cycle as a capture returns the snapshot value held before that capture.
- R4: Reset clears the snapshot to zero and clears `rsp_onehot`.
- R5: An access is recognised only when op0=2'b10, op1=3'b000, CRn=4'b1110, CRm=4'b1100 and op2=3'b000. A cycle with a mismatching encoding, or with no request, produces `rsp_onehot` = 4'b0000 in the next cycle.
- R6: If any of `has_icnt`, `has_snap` or `has_aa64` is low, a recognised access returns undefined.
- R7: A recognised access with `cur_el`=0 returns undefined.
- R8: At EL1 or EL2, the first check returns undefined when `has_el3`, `sdd_undef_prio` are high and `el3_snap_en` is low. This check takes priority over every trap.
- R9: At EL1 only, the second check traps to EL2 when `el2_enabled` and `has_fgt2` are high and either (`has_el3` high and `el3_fgt2_en` low) or `el2_snapdata_rd` is low.
- R10: At EL1 or EL2, the third check fires when `has_el3` is high and `el3_snap_en` is low. It returns undefined if `sdd_undef` is high and traps to EL3 otherwise. If no check fires, the access reads.
- R11: A recognised access at EL3, with all features present, always reads.
- R12: `rsp_onehot` is encoded as {read, undef, trap_el2, trap_el3} (bit 3 down to bit 0). It is at most one-hot and valid the cycle after `req_valid`. `rsp_class` is 6'h18 on either trap and 0 otherwise. `rsp_data` is zero unless the read bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_value | input | 64 | Live instruction counter value |
| cap_strobe | input | 1 | Capture event strobe |
| cap_ok | input | 1 | Capture event succeeded |
| req_valid | input | 1 | Access request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level (0 to 3) |
| has_icnt | input | 1 | Instruction counter feature present |
| has_snap | input | 1 | Snapshot feature present |
| has_aa64 | input | 1 | 64-bit execution state present |
| has_el3 | input | 1 | EL3 implemented |
| has_fgt2 | input | 1 | Second fine-grained trap set implemented |
| el2_enabled | input | 1 | EL2 enabled in current state |
| sdd_undef_prio | input | 1 | Debug-disable undefined takes priority |
| sdd_undef | input | 1 | Debug-disable makes access undefined |
| el3_snap_en | input | 1 | EL3 control: snapshot access enabled |
| el3_fgt2_en | input | 1 | EL3 control: second fine-grained traps enabled |
| el2_snapdata_rd | input | 1 | EL2 control: snapshot data read allowed |
| rsp_onehot | output | 4 | Outcome {read, undef, trap_el2, trap_el3} |
| rsp_class | output | 6 | Trap class, 0x18 on either trap |
| rsp_data | output | 64 | Snapshot value when the read bit is set |

## Verification
Every outcome, its class and its data are registered once, so they appear on the ports one clock edge after the request cycle. A capture is visible in the snapshot one edge after the strobe, so the earliest read that can see it is requested in the following cycle. The bench drives inputs on the falling edge and holds them through one rising edge. It samples at the next falling edge, exactly one edge after the stimulus. It then drops the request and relies on the *retire* transition to clear the outputs before the next vector.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic [2:0] {
        OC_NONE,
        OC_READ,
        OC_UNDEF,
        OC_TRAP_EL2,
        OC_TRAP_EL3
    } outcome_e;

    typedef enum logic {
        S_IDLE,
        S_RESP
    } rsp_state_e;

    localparam logic [1:0] ENC_OP0 = 2'b10;
    localparam logic [2:0] ENC_OP1 = 3'b000;
    localparam logic [3:0] ENC_CRN = 4'b1110;
    localparam logic [3:0] ENC_CRM = 4'b1100;
    localparam logic [2:0] ENC_OP2 = 3'b000;

    localparam logic [1:0] EL_0 = 2'd0;
    localparam logic [1:0] EL_1 = 2'd1;
    localparam logic [1:0] EL_2 = 2'd2;
    localparam logic [1:0] EL_3 = 2'd3;

endpackage

// File: rtl/snap_capture_reg.sv
module snap_capture_reg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt_value,
    input  logic              cap_strobe,
    input  logic              cap_ok,
    output logic [DATA_W-1:0] snap_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (cap_strobe && cap_ok) begin
            snap_q <= cnt_value;
        end
    end
endmodule

// File: rtl/snap_encoding_match.sv
module snap_encoding_match
    import snap_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    always_comb begin
        hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN)
           && (crm == ENC_CRM) && (op2 == ENC_OP2);
    end
endmodule

// File: rtl/snap_access_resolver.sv
module snap_access_resolver
    import snap_pkg::*;
(
    input  logic     enc_hit,
    input  logic [1:0] cur_el,
    input  logic     has_icnt,
    input  logic     has_snap,
    input  logic     has_aa64,
    input  logic     has_el3,
    input  logic     has_fgt2,
    input  logic     el2_enabled,
    input  logic     sdd_undef_prio,
    input  logic     sdd_undef,
    input  logic     el3_snap_en,
    input  logic     el3_fgt2_en,
    input  logic     el2_snapdata_rd,
    output outcome_e decision
);
    logic feat_ok;
    logic prio_undef;
    logic fgt_trap;
    logic el3_block;

    always_comb begin
        feat_ok    = has_icnt && has_snap && has_aa64;
        prio_undef = has_el3 && sdd_undef_prio && !el3_snap_en;
        fgt_trap   = el2_enabled && has_fgt2
                  && ((has_el3 && !el3_fgt2_en) || !el2_snapdata_rd);
        el3_block  = has_el3 && !el3_snap_en;
    end

    always_comb begin
        decision = OC_NONE;
        if (!enc_hit) begin
            decision = OC_NONE;
        end else if (!feat_ok) begin
            decision = OC_UNDEF;
        end else begin
            unique case (cur_el)
                EL_0: decision = OC_UNDEF;
                EL_1: begin
                    if (prio_undef)     decision = OC_UNDEF;
                    else if (fgt_trap)  decision = OC_TRAP_EL2;
                    else if (el3_block) decision = sdd_undef ? OC_UNDEF : OC_TRAP_EL3;
                    else                decision = OC_READ;
                end
                EL_2: begin
                    if (prio_undef)     decision = OC_UNDEF;
                    else if (el3_block) decision = sdd_undef ? OC_UNDEF : OC_TRAP_EL3;
                    else                decision = OC_READ;
                end
                EL_3: decision = OC_READ;
                default: decision = OC_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/snap_access_unit.sv
module snap_access_unit
    import snap_pkg::*;
#(
    parameter int          DATA_W     = 64,
    parameter int          CLASS_W    = 6,
    parameter logic [5:0]  TRAP_CLASS = 6'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  cnt_value,
    input  logic               cap_strobe,
    input  logic               cap_ok,
    input  logic               req_valid,
    input  logic [1:0]         req_op0,
    input  logic [2:0]         req_op1,
    input  logic [3:0]         req_crn,
    input  logic [3:0]         req_crm,
    input  logic [2:0]         req_op2,
    input  logic [1:0]         cur_el,
    input  logic               has_icnt,
    input  logic               has_snap,
    input  logic               has_aa64,
    input  logic               has_el3,
    input  logic               has_fgt2,
    input  logic               el2_enabled,
    input  logic               sdd_undef_prio,
    input  logic               sdd_undef,
    input  logic               el3_snap_en,
    input  logic               el3_fgt2_en,
    input  logic               el2_snapdata_rd,
    output logic [3:0]         rsp_onehot,
    output logic [CLASS_W-1:0] rsp_class,
    output logic [DATA_W-1:0]  rsp_data
);
    localparam int OUT_W = 4;
    localparam logic [CLASS_W-1:0] CLASS_CODE = CLASS_W'(TRAP_CLASS);

    logic [DATA_W-1:0] snap_value;
    logic              enc_hit;
    outcome_e          decision;
    rsp_state_e        state_q;
    rsp_state_e        state_d;
    outcome_e          held_q;
    logic [DATA_W-1:0] held_data_q;

    snap_capture_reg #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_value  (cnt_value),
        .cap_strobe (cap_strobe),
        .cap_ok     (cap_ok),
        .snap_q     (snap_value)
    );

    snap_encoding_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    snap_access_resolver u_resolve (
        .enc_hit         (enc_hit),
        .cur_el          (cur_el),
        .has_icnt        (has_icnt),
        .has_snap        (has_snap),
        .has_aa64        (has_aa64),
        .has_el3         (has_el3),
        .has_fgt2        (has_fgt2),
        .el2_enabled     (el2_enabled),
        .sdd_undef_prio  (sdd_undef_prio),
        .sdd_undef       (sdd_undef),
        .el3_snap_en     (el3_snap_en),
        .el3_fgt2_en     (el3_fgt2_en),
        .el2_snapdata_rd (el2_snapdata_rd),
        .decision        (decision)
    );

    // Next state: accept on a request, retire otherwise
    always_comb begin
        state_d = req_valid ? S_RESP : S_IDLE;
    end

    // State register and the outcome held for the response cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            held_q      <= OC_NONE;
            held_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                held_q      <= decision;
                held_data_q <= snap_value;
            end
        end
    end

    // Outputs
    always_comb begin
        rsp_onehot = '0;
        rsp_class  = '0;
        rsp_data   = '0;
        unique case (state_q)
            S_IDLE: ;
            S_RESP: begin
                unique case (held_q)
                    OC_READ: begin
                        rsp_onehot = OUT_W'(4'b1000);
                        rsp_data   = held_data_q;
                    end
                    OC_UNDEF:    rsp_onehot = OUT_W'(4'b0100);
                    OC_TRAP_EL2: begin
                        rsp_onehot = OUT_W'(4'b0010);
                        rsp_class  = CLASS_CODE;
                    end
                    OC_TRAP_EL3: begin
                        rsp_onehot = OUT_W'(4'b0001);
                        rsp_class  = CLASS_CODE;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/snap_access_checker.sv
module snap_access_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] cnt_value,
    input logic        cap_strobe,
    input logic        cap_ok,
    input logic [63:0] snap_value,
    input logic        req_valid,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic [1:0]  cur_el,
    input logic        has_icnt,
    input logic        has_snap,
    input logic        has_aa64,
    input logic [3:0]  rsp_onehot,
    input logic [5:0]  rsp_class,
    input logic [63:0] rsp_data
);
    logic hit;
    logic feat;
    assign hit  = req_op0 == 2'b10 && req_op1 == 3'b000 && req_crn == 4'b1110
               && req_crm == 4'b1100 && req_op2 == 3'b000;
    assign feat = has_icnt && has_snap && has_aa64;

    AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe && cap_ok |=> snap_value == $past(cnt_value)); // R1
    AST_NO_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_strobe && cap_ok) |=> $stable(snap_value)); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && hit) |=> rsp_onehot == 4'b0000); // R5
    AST_FEATURE_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && hit && !feat |=> rsp_onehot == 4'b0100); // R6
    AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && hit && cur_el == 2'd0 |=> rsp_onehot == 4'b0100); // R7
    AST_EL3_READS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && hit && feat && cur_el == 2'd3 |=> rsp_onehot == 4'b1000); // R11
    AST_ONEHOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_onehot)); // R12
    AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_class == ((rsp_onehot[1] || rsp_onehot[0]) ? 6'h18 : 6'h00)); // R12
    AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_onehot[3] |-> rsp_data == 64'd0); // R12
endmodule

bind snap_access_unit snap_access_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_value  (cnt_value),
    .cap_strobe (cap_strobe),
    .cap_ok     (cap_ok),
    .snap_value (snap_value),
    .req_valid  (req_valid),
    .req_op0    (req_op0),
    .req_op1    (req_op1),
    .req_crn    (req_crn),
    .req_crm    (req_crm),
    .req_op2    (req_op2),
    .cur_el     (cur_el),
    .has_icnt   (has_icnt),
    .has_snap   (has_snap),
    .has_aa64   (has_aa64),
    .rsp_onehot (rsp_onehot),
    .rsp_class  (rsp_class),
    .rsp_data   (rsp_data)
);

// File: tb/tb_snap_access_unit.sv
`timescale 1ns/1ps
module tb_snap_access_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_value = '0;
    logic        cap_strobe = 1'b0, cap_ok = 1'b0, req_valid = 1'b0;
    logic [1:0]  req_op0 = 2'b10;
    logic [2:0]  req_op1 = 3'b000;
    logic [3:0]  req_crn = 4'b1110, req_crm = 4'b1100;
    logic [2:0]  req_op2 = 3'b000;
    logic [1:0]  cur_el = 2'd3;
    logic has_icnt = 1, has_snap = 1, has_aa64 = 1, has_el3 = 0, has_fgt2 = 0;
    logic el2_enabled = 0, sdd_undef_prio = 0, sdd_undef = 0;
    logic el3_snap_en = 0, el3_fgt2_en = 0, el2_snapdata_rd = 0;
    logic [3:0]  rsp_onehot;
    logic [5:0]  rsp_class;
    logic [63:0] rsp_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    snap_access_unit dut (.*);

    // {features[2:0], el[1:0], el3, fgt2, el2en, prio, sdd, snapen, fgt2en, rdallow, expect[3:0]}
    localparam int NV = 17;
    localparam logic [16:0] VEC [NV] = '{
        {3'b111, 2'd1, 8'b0000_0000, 4'b1000},
        {3'b111, 2'd1, 8'b1001_0000, 4'b0100},
        {3'b111, 2'd1, 8'b0110_0000, 4'b0010},
        {3'b111, 2'd1, 8'b1110_0101, 4'b0010},
        {3'b111, 2'd1, 8'b1110_0111, 4'b1000},
        {3'b111, 2'd1, 8'b1000_1000, 4'b0100},
        {3'b111, 2'd1, 8'b1000_0000, 4'b0001},
        {3'b111, 2'd2, 8'b0110_0000, 4'b1000},
        {3'b111, 2'd2, 8'b1110_0000, 4'b0001},
        {3'b111, 2'd2, 8'b1001_0000, 4'b0100},
        {3'b111, 2'd3, 8'b1001_0000, 4'b1000},
        {3'b111, 2'd0, 8'b0000_0111, 4'b0100},
        {3'b011, 2'd3, 8'b0000_0000, 4'b0100},
        {3'b101, 2'd1, 8'b0000_0000, 4'b0100},
        {3'b110, 2'd2, 8'b0000_0000, 4'b0100},
        {3'b111, 2'd1, 8'b1111_0000, 4'b0100},
        {3'b111, 2'd1, 8'b1100_0000, 4'b0001}
    };

    localparam logic [63:0] SNAP_A = 64'hDEAD_BEEF_0123_4567;
    localparam logic [63:0] SNAP_B = 64'h0F0F_1234_5678_9ABC;
    localparam logic [63:0] SNAP_C = 64'hFFFF_FFFF_FFFF_FFFE;

    task automatic check(input string req, input logic [3:0] exp_oh,
                         input logic [63:0] exp_data);
        logic [5:0] exp_cls;
        exp_cls = (exp_oh[1] || exp_oh[0]) ? 6'h18 : 6'h00;
        n_tests++;
        if (rsp_onehot !== exp_oh || rsp_class !== exp_cls || rsp_data !== exp_data) begin
            n_fail++;
            $display("FAIL %s: got oh=%b cls=%h data=%h, expected oh=%b cls=%h data=%h",
                     req, rsp_onehot, rsp_class, rsp_data, exp_oh, exp_cls, exp_data);
        end
    endtask

    // Issue one request, sample one edge later, then drop it
    task automatic access(input logic cap);
        @(negedge clk);
        req_valid = 1'b1;
        if (cap) begin cap_strobe = 1'b1; cap_ok = 1'b1; end
        @(negedge clk);
        req_valid = 1'b0;
        cap_strobe = 1'b0;
        cap_ok = 1'b0;
    endtask

    task automatic capture(input logic [63:0] v, input logic ok);
        @(negedge clk);
        cnt_value = v; cap_strobe = 1'b1; cap_ok = ok;
        @(negedge clk);
        cap_strobe = 1'b0; cap_ok = 1'b0;
    endtask

    task automatic set_all_ok_el3();
        {has_icnt, has_snap, has_aa64} = 3'b111;
        cur_el = 2'd3;
        {req_op0, req_op1, req_crn, req_crm, req_op2} = {2'b10, 3'b000, 4'b1110, 4'b1100, 3'b000};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        check("R4 reset outputs", 4'b0000, 64'd0);
        set_all_ok_el3();
        access(1'b0);
        check("R4 snapshot cleared", 4'b1000, 64'd0);

        // R1: capture then read
        capture(SNAP_A, 1'b1);
        access(1'b0);
        check("R1 capture", 4'b1000, SNAP_A);

        // Permission table: R6..R11
        for (int i = 0; i < NV; i++) begin
            {has_icnt, has_snap, has_aa64} = VEC[i][16:14];
            cur_el = VEC[i][13:12];
            {has_el3, has_fgt2, el2_enabled, sdd_undef_prio, sdd_undef,
             el3_snap_en, el3_fgt2_en, el2_snapdata_rd} = VEC[i][11:4];
            access(1'b0);
            check($sformatf("R6-table vector %0d (R7 R8 R9 R10 R11)", i),
                  VEC[i][3:0], VEC[i][3] ? SNAP_A : 64'd0);
        end
        // R12: after the request drops the response retires
        @(negedge clk);
        check("R12 retire", 4'b0000, 64'd0);

        set_all_ok_el3();
        // R2: strobe without success
        capture(SNAP_B, 1'b0);
        access(1'b0);
        check("R2 failed capture ignored", 4'b1000, SNAP_A);

        // R3: read in capture cycle returns old value, then the new one
        cnt_value = SNAP_B;
        access(1'b1);
        check("R3 same-cycle read old value", 4'b1000, SNAP_A);
        access(1'b0);
        check("R3 following read new value", 4'b1000, SNAP_B);

        // R5: mismatched encodings
        req_crm = 4'b1101;
        access(1'b0);
        check("R5 CRm mismatch", 4'b0000, 64'd0);
        req_crm = 4'b1100; req_op0 = 2'b11;
        access(1'b0);
        check("R5 op0 mismatch", 4'b0000, 64'd0);
        req_op0 = 2'b10; req_op2 = 3'b001; has_icnt = 1'b0;
        access(1'b0);
        check("R5 op2 mismatch beats missing feature", 4'b0000, 64'd0);
        set_all_ok_el3();

        // R1: boundary value capture
        capture(SNAP_C, 1'b1);
        access(1'b0);
        check("R1 all-ones-ish capture", 4'b1000, SNAP_C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule